// File: doc/BRIEF.md
# Packetized OTP Read Controller

This block is the read side of a one-time-programmable word array whose contents are laid out as a chain of variable-length packets. A packet is made of one header word followed by a payload. Bits 15:8 of the header hold a size field, and the payload is that field plus one words long. The next packet's header sits right after the payload. A header whose size field is zero ends the chain.

Software places a word address in the mode register and then writes the start bit in the control register. The controller walks the chain from word 0, one header per cycle, until it reaches the packet whose span contains that address. It then copies the header and every payload word into local buffers, and it holds a busy flag while it does this. Once busy clears, software reads the header from the header register. To read the payload, software clears the index register and reads the data register again and again. Each read returns the next payload word.

The array itself is outside the block. The controller drives a word address, and the array answers within the same cycle.

Top module: `pkt_otp_rd_ctrl`

## Requirements
- R1: After reset the status register (byte offset 0x0C) reads 0, the header register (0x20) reads 0 and the data register (0x24) reads 0.
- R2: A bus write to the control register (0x00) with bit 6 set, made while idle, starts a packet read. Status bit 6 reads 1 in the cycle after that write and returns to 0 once the buffers are filled.
- R3: The mode register (0x04) holds the requested word address in bits 31:16. A read of it returns those bits, with bits 15:0 as zero.
- R4: For any requested address A with start_k <= A < start_k + size_k + 2, the header register afterwards returns the header word of packet k. The result does not depend on where A falls in that range.
- R5: After software writes 0 to the index register (0x08), successive reads of the data register return payload words 0, 1, ..., size_k of the loaded packet, in order.
- R6: Each data register read advances the index by one, and the index register reads back the current index.
- R7: A data register read with the index at or beyond the payload length (size field + 1) returns 0.
- R8: If the walk reaches a header whose size field is zero before reaching the requested address, the header register reads 0 and every data register read returns 0.
- R9: A control write with bit 6 set, made while busy, is ignored. The read in progress completes for the address it latched at its start, even if the mode register has changed since.
- R10: A control write with bit 6 clear starts nothing, and status bit 6 stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a data register read has a side effect) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the offset on bus_addr |
| otp_addr | output | 16 | Word address into the array |
| otp_rdata | input | 32 | Array word at otp_addr, same cycle |

## Verification
The bench requests addresses at the first word, the last word and the interior of several packets. A controller that chose a packet by the wrong bound would hand back the neighbouring packet's header whenever the request hit the last word of a span. The bench drains every payload and then reads once more. An off-by-one in the payload length would either drop the final word or return a stale word where zero is expected. The bench also issues requests past the chain terminator after a packet is already loaded, which catches a design that leaves old buffer contents visible. Finally, it changes the mode register and re-issues the start bit in the middle of a long walk, which exposes a controller that restarts or follows the newer address.

// File: rtl/otpr_pkg.sv
package otpr_pkg;
  localparam int WORD_W = 32;
  localparam int WA_W   = 16;
  localparam int SZ_W   = 8;
  localparam int SZ_LSB = 8;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [WA_W-1:0]   waddr_t;
  typedef logic [SZ_W-1:0]   size_t;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_HDR  = 2'd1,
    W_LOAD = 2'd2
  } walk_state_t;

  // size field taken from a header word
  function automatic size_t hdr_size(word_t hdr);
    return hdr[SZ_LSB +: SZ_W];
  endfunction

  // first word after the packet, one bit wider to avoid wrap
  function automatic logic [WA_W:0] next_start(waddr_t start, size_t sz);
    return {1'b0, start} + {{(WA_W+1-SZ_W){1'b0}}, sz} + (WA_W+1)'(2);
  endfunction

  // true when tgt lies inside the span of the packet at start
  function automatic logic pkt_holds(waddr_t tgt, waddr_t start, size_t sz);
    return (tgt >= start) && ({1'b0, tgt} < next_start(start, sz));
  endfunction

  // payload length in words for a size field
  function automatic logic [SZ_W:0] pay_len(size_t sz);
    return {1'b0, sz} + (SZ_W+1)'(1);
  endfunction
endpackage

// File: rtl/otpr_regbank.sv
module otpr_regbank
  import otpr_pkg::*;
#(
  parameter int BUS_AW = 8,
  parameter int IW     = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  word_t             bus_wdata,
  output word_t             bus_rdata,
  output logic              start_req,
  output waddr_t            mode_addr,
  output logic              idx_wr,
  output logic [IW-1:0]     idx_wdata,
  output logic              data_rd,
  input  logic              busy,
  input  word_t             hdr_word,
  input  word_t             data_word,
  input  logic [IW-1:0]     idx
);
  localparam logic [BUS_AW-1:0] OFF_CTRL = BUS_AW'(8'h00);
  localparam logic [BUS_AW-1:0] OFF_MODE = BUS_AW'(8'h04);
  localparam logic [BUS_AW-1:0] OFF_IDX  = BUS_AW'(8'h08);
  localparam logic [BUS_AW-1:0] OFF_STAT = BUS_AW'(8'h0C);
  localparam logic [BUS_AW-1:0] OFF_HDR  = BUS_AW'(8'h20);
  localparam logic [BUS_AW-1:0] OFF_DATA = BUS_AW'(8'h24);
  localparam int GO_BIT   = 6;
  localparam int BUSY_BIT = 6;
  localparam int MA_LSB   = 16;

  waddr_t mode_q;

  assign start_req = bus_wr && (bus_addr == OFF_CTRL) && bus_wdata[GO_BIT];
  assign idx_wr    = bus_wr && (bus_addr == OFF_IDX);
  assign idx_wdata = bus_wdata[IW-1:0];
  assign data_rd   = bus_rd && (bus_addr == OFF_DATA);
  assign mode_addr = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
    end else if (bus_wr && (bus_addr == OFF_MODE)) begin
      mode_q <= bus_wdata[MA_LSB +: WA_W];
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      OFF_MODE: bus_rdata[MA_LSB +: WA_W] = mode_q;
      OFF_IDX:  bus_rdata[IW-1:0] = idx;
      OFF_STAT: bus_rdata[BUSY_BIT] = busy;
      OFF_HDR:  bus_rdata = hdr_word;
      OFF_DATA: bus_rdata = data_word;
      default:  bus_rdata = '0;
    endcase
  end

  wire unused_wdata = ^{bus_wdata[MA_LSB-1:IW], 1'b0};
endmodule

// File: rtl/otpr_walker.sv
module otpr_walker
  import otpr_pkg::*;
#(
  parameter int OTP_WORDS = 2816,
  parameter int IW        = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  waddr_t        mode_addr,
  output waddr_t        otp_addr,
  input  word_t         otp_rdata,
  output logic          buf_we,
  output size_t         buf_waddr,
  output word_t         buf_wdata,
  output word_t         hdr_word,
  output logic [IW-1:0] plen,
  output logic          busy,
  output logic          start_acc,
  output logic          found_hit,
  output logic          end_hit,
  output logic          load_done,
  output waddr_t        target,
  output waddr_t        cur_start,
  output size_t         cur_size
);
  walk_state_t   state_q;
  waddr_t        tgt_q, cur_q;
  size_t         cnt_q, size_q;
  word_t         hdr_q;
  logic [IW-1:0] plen_q;
  logic          beyond;
  size_t         rd_sz;

  assign busy      = (state_q != W_IDLE);
  assign start_acc = start_req && !busy;
  assign rd_sz     = hdr_size(otp_rdata);
  assign beyond    = ({{(32-WA_W){1'b0}}, cur_q} >= 32'(OTP_WORDS));
  assign end_hit   = (state_q == W_HDR) && ((rd_sz == '0) || beyond);
  assign found_hit = (state_q == W_HDR) && !end_hit && pkt_holds(tgt_q, cur_q, rd_sz);
  assign load_done = (state_q == W_LOAD) && (cnt_q == size_q);

  always_comb begin
    unique case (state_q)
      W_LOAD:  otp_addr = cur_q + WA_W'(1) + {{(WA_W-SZ_W){1'b0}}, cnt_q};
      default: otp_addr = cur_q;
    endcase
  end

  assign buf_we    = (state_q == W_LOAD);
  assign buf_waddr = cnt_q;
  assign buf_wdata = otp_rdata;
  assign hdr_word  = hdr_q;
  assign plen      = plen_q;
  assign target    = tgt_q;
  assign cur_start = cur_q;
  assign cur_size  = rd_sz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= W_IDLE;
      tgt_q   <= '0;
      cur_q   <= '0;
      cnt_q   <= '0;
      size_q  <= '0;
      hdr_q   <= '0;
      plen_q  <= '0;
    end else begin
      unique case (state_q)
        W_IDLE: begin
          if (start_acc) begin
            tgt_q   <= mode_addr;
            cur_q   <= '0;
            state_q <= W_HDR;
          end
        end
        W_HDR: begin
          if (end_hit) begin
            hdr_q   <= '0;
            plen_q  <= '0;
            state_q <= W_IDLE;
          end else if (found_hit) begin
            hdr_q   <= otp_rdata;
            size_q  <= rd_sz;
            plen_q  <= IW'(pay_len(rd_sz));
            cnt_q   <= '0;
            state_q <= W_LOAD;
          end else begin
            cur_q <= next_start(cur_q, rd_sz)[WA_W-1:0];
          end
        end
        W_LOAD: begin
          if (load_done) state_q <= W_IDLE;
          else           cnt_q   <= cnt_q + SZ_W'(1);
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/otpr_paybuf.sv
module otpr_paybuf
  import otpr_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int IW    = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_we,
  input  size_t         buf_waddr,
  input  word_t         buf_wdata,
  input  logic [IW-1:0] plen,
  input  logic          idx_wr,
  input  logic [IW-1:0] idx_wdata,
  input  logic          data_rd,
  output logic [IW-1:0] idx,
  output word_t         data_word
);
  localparam int MW = $clog2(DEPTH);

  word_t         mem [DEPTH];
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (buf_we) mem[buf_waddr[MW-1:0]] <= buf_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_wr) begin
      idx_q <= idx_wdata;
    end else if (data_rd && (idx_q != '1)) begin
      idx_q <= idx_q + IW'(1);
    end
  end

  assign idx       = idx_q;
  assign data_word = (idx_q < plen) ? mem[idx_q[MW-1:0]] : '0;
endmodule

// File: rtl/pkt_otp_rd_ctrl.sv
module pkt_otp_rd_ctrl
  import otpr_pkg::*;
#(
  parameter int OTP_WORDS = 2816,
  parameter int BUS_AW    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [BUS_AW-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [15:0]       otp_addr,
  input  logic [31:0]       otp_rdata
);
  localparam int DEPTH = 1 << SZ_W;
  localparam int IW    = SZ_W + 1;

  logic          start_req, idx_wr, data_rd, busy;
  logic          start_acc, found_hit, end_hit, load_done;
  waddr_t        mode_addr, target, cur_start;
  size_t         cur_size, buf_waddr;
  logic          buf_we;
  word_t         buf_wdata, hdr_word, data_word;
  logic [IW-1:0] idx_wdata, idx, plen;

  otpr_regbank #(.BUS_AW(BUS_AW), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .start_req(start_req), .mode_addr(mode_addr), .idx_wr(idx_wr),
    .idx_wdata(idx_wdata), .data_rd(data_rd), .busy(busy),
    .hdr_word(hdr_word), .data_word(data_word), .idx(idx)
  );

  otpr_walker #(.OTP_WORDS(OTP_WORDS), .IW(IW)) u_walk (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .mode_addr(mode_addr),
    .otp_addr(otp_addr), .otp_rdata(otp_rdata), .buf_we(buf_we),
    .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .hdr_word(hdr_word),
    .plen(plen), .busy(busy), .start_acc(start_acc), .found_hit(found_hit),
    .end_hit(end_hit), .load_done(load_done), .target(target),
    .cur_start(cur_start), .cur_size(cur_size)
  );

  otpr_paybuf #(.DEPTH(DEPTH), .IW(IW)) u_buf (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .plen(plen), .idx_wr(idx_wr),
    .idx_wdata(idx_wdata), .data_rd(data_rd), .idx(idx),
    .data_word(data_word)
  );
endmodule

// File: rtl/otpr_checker.sv
module otpr_checker
  import otpr_pkg::*;
#(
  parameter int IW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          start_acc,
  input logic          found_hit,
  input logic          end_hit,
  input logic          load_done,
  input waddr_t        target,
  input waddr_t        cur_start,
  input size_t         cur_size,
  input word_t         hdr_word,
  input logic [IW-1:0] plen,
  input logic          data_rd,
  input logic          idx_wr,
  input logic [IW-1:0] idx,
  input word_t         bus_rdata
);
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_acc |=> busy); // R2
  AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_done || end_hit) |=> !busy); // R2
  AST_FOUND_IN_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    found_hit |-> (target >= cur_start) &&
      ({1'b0, target} < ({1'b0, cur_start} + 17'(cur_size) + 17'd2))); // R4
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !idx_wr && (idx != '1)) |=> (idx == $past(idx) + IW'(1))); // R6
  AST_PAST_END_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && (idx >= plen)) |-> (bus_rdata == '0)); // R7
  AST_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    end_hit |=> ((hdr_word == '0) && (plen == '0))); // R8
  AST_TARGET_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(target)); // R9
endmodule

bind pkt_otp_rd_ctrl otpr_checker #(.IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .start_acc(start_acc),
  .found_hit(found_hit), .end_hit(end_hit), .load_done(load_done),
  .target(target), .cur_start(cur_start), .cur_size(cur_size),
  .hdr_word(hdr_word), .plen(plen), .data_rd(data_rd), .idx_wr(idx_wr),
  .idx(idx), .bus_rdata(bus_rdata)
);

// File: tb/pkt_otp_rd_ctrl_bench.sv
module pkt_otp_rd_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [15:0] otp_addr;
  logic [31:0] otp_rdata;
  logic [31:0] rom [32];
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  assign otp_rdata = (otp_addr < 16'd32) ? rom[otp_addr[4:0]] : 32'h0;

  pkt_otp_rd_ctrl u_pkt_otp_rd_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .otp_addr(otp_addr), .otp_rdata(otp_rdata)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  // bench model: start word of the packet holding addr, or -1
  function automatic int find_pkt(int addr);
    int st = 0;
    for (int n = 0; n < 32; n++) begin
      if (st >= 32 || rom[st][15:8] == 8'd0) return -1;
      if (addr >= st && addr < st + int'(rom[st][15:8]) + 2) return st;
      st = st + int'(rom[st][15:8]) + 2;
    end
    return -1;
  endfunction

  task automatic wait_idle(string req);
    logic [31:0] s;
    int n = 0;
    do begin
      rd(8'h0C, s);
      n++;
    end while (s[6] && n < 3000);
    check(req, {31'd0, s[6]}, 32'd0);
  endtask

  task automatic start_read(int addr);
    wr(8'h04, {addr[15:0], 16'h0});
    wr(8'h00, 32'h40);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(8'h0C, v); check("R1 status", v, 0);
    rd(8'h20, v); check("R1 header", v, 0);
    rd(8'h24, v); check("R1 data", v, 0);
  endtask

  task automatic t_no_go;
    logic [31:0] v;
    wr(8'h00, 32'h0000_00BF);
    rd(8'h0C, v); check("R10 no start", v, 0);
  endtask

  task automatic t_mode;
    logic [31:0] v;
    wr(8'h04, 32'h0005_1234);
    rd(8'h04, v); check("R3 mode readback", v, 32'h0005_0000);
  endtask

  task automatic t_packet(int addr);
    logic [31:0] v;
    int st = find_pkt(addr);
    int len = int'(rom[st][15:8]) + 1;
    start_read(addr);
    rd(8'h0C, v); check("R2 busy set", {31'd0, v[6]}, 1);
    wait_idle("R2 busy clears");
    rd(8'h20, v); check($sformatf("R4 header addr %0d", addr), v, rom[st]);
    wr(8'h08, 0);
    for (int i = 0; i < len; i++) begin
      rd(8'h24, v); check($sformatf("R5 payload %0d", i), v, rom[st + 1 + i]);
    end
    rd(8'h08, v); check("R6 index", v, len);
    rd(8'h24, v); check("R7 past end", v, 0);
    rd(8'h08, v); check("R6 index step", v, len + 1);
  endtask

  task automatic t_end(int addr);
    logic [31:0] v;
    start_read(addr);
    wait_idle("R8 done");
    rd(8'h20, v); check("R8 header zero", v, 0);
    wr(8'h08, 0);
    rd(8'h24, v); check("R8 data zero", v, 0);
  endtask

  task automatic t_busy;
    logic [31:0] v;
    start_read(12);
    wr(8'h04, 32'h0);
    wr(8'h00, 32'h40);
    wait_idle("R9 done");
    rd(8'h20, v); check("R9 header kept", v, rom[find_pkt(12)]);
    wr(8'h08, 0);
    rd(8'h24, v); check("R9 payload kept", v, rom[find_pkt(12) + 1]);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) rom[i] = 32'h0;
    // packet at 0: size 2, packet at 4: size 1, packet at 7: size 4, end at 13
    rom[0] = 32'hC0DE_0200;
    rom[4] = 32'hC0DE_0101;
    rom[7] = 32'hC0DE_0402;
    for (int i = 1; i < 4; i++)  rom[i] = 32'h1000_0000 + i * 3;
    for (int i = 5; i < 7; i++)  rom[i] = 32'h2000_0000 + i * 5;
    for (int i = 8; i < 13; i++) rom[i] = 32'h3000_0000 + i * 7;
    rom[20] = 32'hDEAD_0300;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_no_go();
    t_mode();
    t_packet(0);
    t_packet(3);
    t_packet(4);
    t_packet(6);
    t_packet(7);
    t_packet(12);
    t_end(13);
    t_end(20);
    t_packet(5);
    t_busy();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule